// File: doc/BRIEF.md
# Stacked-Carrier Three-Phase Level Modulator

This block turns three per-phase duty values into commanded output levels for an inverter with between four and eight voltage levels. It builds a set of in-phase triangle carriers stacked one above another across full scale, all taken from a single up/down counter. For each phase it reports how many carriers lie strictly below that phase's duty value. The result is a level index from 0 to N_LEVELS-1, which a downstream redundant-state selector or gate driver consumes.

Duty values and the carrier half-period are sampled only at the turning points of the triangle. A one-cycle strobe marks the first cycle in which the levels reflect a fresh sample, so downstream logic can pick them up. The half-period is given in clock cycles through a port. At a 200 MHz clock, a 5 kHz carrier corresponds to a half-period of 20000.

Top module: `lscm_modulator`

## Requirements
- R1: Each phase's level equals the number of carriers k (0 <= k < N_LEVELS-1) for which duty/2^DUTY_W is strictly greater than the carrier value. A duty equal to a carrier does not count as above it.
- R2: All phases are compared against the same carriers. A phase whose sampled duty is greater than or equal to another phase's sampled duty never has a lower level, and equal duties give equal levels.
- R3: N_LEVELS may be 4 to 8, with C = N_LEVELS-1 carriers. With the triangle counter at value t and half-period H, carrier k has value (k + t/H)/C, so it spans the band from k/C to (k+1)/C.
- R4: Levels stay within 0 to N_LEVELS-1. A duty of 0 always gives level 0. A duty of 2^DUTY_W-1 gives level N_LEVELS-1 in the strobe cycle that follows a valley.
- R5: The counter starts at 0 and rises by one per clock to H. At H it reverses and falls by one per clock to 0, so the strobe recurs every H clocks. H is taken from per_i at each valley, with values below 2 treated as 2.
- R6: Duty values are captured only when the counter is at the peak (t = H while rising) or at the valley (t = 0 while falling). A duty change at any other time has no effect on the levels until the next turning point.
- R7: strb_o is high for exactly one clock in the cycle after each peak and each valley. In that cycle the levels already use the newly captured duty values.
- R8: While rst_ni is low, all levels are 0, strb_o is 0 and the counter sits at the valley, so the first capture happens on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_i | input | PER_W | Carrier half-period in clocks, taken at each valley |
| duty_i | input | NPH*DUTY_W | Per-phase unsigned duty fractions, phase p in bits [p*DUTY_W +: DUTY_W] |
| lvl_o | output | NPH*LW | Per-phase commanded level, LW = $clog2(N_LEVELS) |
| strb_o | output | 1 | One-cycle marker after each carrier peak and valley |

## Verification
The assertions assume that the half-period input, once clamped, never drops below 2. This keeps strobes at least two clocks apart and means the counter only moves within a single ramp. They also assume that the duty inputs are plain unsigned fractions, so that ordering between phases carries over to ordering between levels. The stimulus draws half-periods between 2 and 40, plus a directed value of 0 to exercise the clamp. Duty values are drawn across the full code range, with the extremes and the exact band edges applied as directed cases. Duties also change on nearly every clock, which exercises the turning-point capture.

// File: rtl/lscm_pkg.sv
package lscm_pkg;
  localparam int unsigned MIN_HALF = 2;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} ramp_dir_e;

  function automatic int unsigned lvl_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lscm_tri_counter.sv
module lscm_tri_counter #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] per_i,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] half_o,
  output logic             peak_o,
  output logic             valley_o
);
  import lscm_pkg::*;

  localparam logic [PER_W-1:0] HALF_MIN = PER_W'(MIN_HALF);

  ramp_dir_e        dir_q;
  logic [PER_W-1:0] cnt_q, half_q, per_eff;

  assign per_eff  = (per_i < HALF_MIN) ? HALF_MIN : per_i;
  assign peak_o   = (dir_q == DIR_UP) && (cnt_q == half_q);
  assign valley_o = (dir_q == DIR_DOWN) && (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign half_o   = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= DIR_DOWN;
      cnt_q  <= '0;
      half_q <= HALF_MIN;
    end else if (dir_q == DIR_UP) begin
      if (peak_o) begin
        dir_q <= DIR_DOWN;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (valley_o) begin
        // new half-period only takes effect on a fresh rising ramp
        dir_q  <= DIR_UP;
        cnt_q  <= PER_W'(1);
        half_q <= per_eff;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lscm_band_cmp.sv
module lscm_band_cmp #(
  parameter int unsigned N_LEVELS = 5,
  parameter int unsigned DUTY_W   = 12,
  parameter int unsigned PER_W    = 16,
  localparam int unsigned LW      = lscm_pkg::lvl_width(N_LEVELS)
) (
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [PER_W-1:0]  cnt_i,
  input  logic [PER_W-1:0]  half_i,
  output logic [LW-1:0]     lvl_o
);
  localparam int unsigned NCAR   = N_LEVELS - 1;
  localparam int unsigned PROD_W = DUTY_W + PER_W + 4;

  logic [PROD_W-1:0] duty_scaled;
  logic [NCAR-1:0]   above;

  // duty*C*H vs (k*H + t)*2^DUTY_W keeps the comparison exact
  assign duty_scaled = PROD_W'(duty_i) * PROD_W'(NCAR) * PROD_W'(half_i);

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic [PROD_W-1:0] car_scaled;
    assign car_scaled = (PROD_W'(k) * PROD_W'(half_i) + PROD_W'(cnt_i)) << DUTY_W;
    assign above[k]   = duty_scaled > car_scaled;
  end

  always_comb begin
    lvl_o = '0;
    for (int k = 0; k < NCAR; k++) lvl_o = lvl_o + LW'(above[k]);
  end
endmodule

// File: rtl/lscm_modulator.sv
module lscm_modulator #(
  parameter int unsigned NPH      = 3,
  parameter int unsigned N_LEVELS = 5,
  parameter int unsigned DUTY_W   = 12,
  parameter int unsigned PER_W    = 16,
  localparam int unsigned LW      = lscm_pkg::lvl_width(N_LEVELS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [PER_W-1:0]             per_i,
  input  logic [NPH-1:0][DUTY_W-1:0]   duty_i,
  output logic [NPH-1:0][LW-1:0]       lvl_o,
  output logic                         strb_o
);
  logic [PER_W-1:0]           cnt_q, half_q;
  logic                       peak, valley, turn;
  logic [NPH-1:0][DUTY_W-1:0] duty_q;
  logic                       strb_q;

  lscm_tri_counter #(.PER_W(PER_W)) u_tri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_i    (per_i),
    .cnt_o    (cnt_q),
    .half_o   (half_q),
    .peak_o   (peak),
    .valley_o (valley)
  );

  assign turn = peak | valley;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      strb_q <= 1'b0;
    end else begin
      strb_q <= turn;
      if (turn) duty_q <= duty_i;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    lscm_band_cmp #(
      .N_LEVELS (N_LEVELS),
      .DUTY_W   (DUTY_W),
      .PER_W    (PER_W)
    ) u_cmp (
      .duty_i (duty_q[p]),
      .cnt_i  (cnt_q),
      .half_i (half_q),
      .lvl_o  (lvl_o[p])
    );
  end

  assign strb_o = strb_q;
endmodule

// File: rtl/lscm_modulator_chk.sv
module lscm_modulator_chk #(
  parameter int unsigned NPH      = 3,
  parameter int unsigned N_LEVELS = 5,
  parameter int unsigned DUTY_W   = 12,
  parameter int unsigned PER_W    = 16,
  localparam int unsigned LW      = lscm_pkg::lvl_width(N_LEVELS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NPH-1:0][LW-1:0]     lvl_i,
  input logic                       strb_i,
  input logic [PER_W-1:0]           cnt_i,
  input logic [PER_W-1:0]           half_i,
  input logic [NPH-1:0][DUTY_W-1:0] duty_i
);
  assert_strb_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i |=> !strb_i);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= half_i) && (half_i >= PER_W'(2)));

  for (genvar p = 0; p < NPH; p++) begin : g_p
    assert_lvl_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(lvl_i[p]) < int'(N_LEVELS));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strb_i |-> $stable(duty_i[p]));

    // between captures the level can cross at most one carrier per clock
    assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strb_i |-> ((lvl_i[p] >= $past(lvl_i[p])) ? (lvl_i[p] - $past(lvl_i[p]))
                                                  : ($past(lvl_i[p]) - lvl_i[p])) <= LW'(1));

    for (genvar q = 0; q < NPH; q++) begin : g_q
      if (p != q) begin : g_pair
        assert_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (duty_i[p] >= duty_i[q]) |-> (lvl_i[p] >= lvl_i[q]));
      end
    end
  end
endmodule

bind lscm_modulator lscm_modulator_chk #(
  .NPH(NPH), .N_LEVELS(N_LEVELS), .DUTY_W(DUTY_W), .PER_W(PER_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lvl_i  (lvl_o),
  .strb_i (strb_o),
  .cnt_i  (cnt_q),
  .half_i (half_q),
  .duty_i (duty_q)
);

// File: tb/lscm_modulator_tb.sv
`timescale 1ns/1ps
module lscm_modulator_tb;
  localparam int DW = 12;
  localparam int PW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [PW-1:0] per_i = 16'd4;
  logic [2:0][DW-1:0] duty_i = '0;
  logic [2:0][2:0] lvl5, lvl8;
  logic strb5, strb8;

  int n_chk = 0, n_err = 0;
  string tag = "R1";
  bit run_chk = 1'b0;

  // model state from R5/R6/R7
  int  mcnt, mhalf;
  bit  mup, mstrb;
  int  mduty[3];

  always #2.5 clk_i = ~clk_i;

  lscm_modulator #(.NPH(3), .N_LEVELS(5), .DUTY_W(DW), .PER_W(PW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_i(per_i), .duty_i(duty_i),
    .lvl_o(lvl5), .strb_o(strb5));

  lscm_modulator #(.NPH(3), .N_LEVELS(8), .DUTY_W(DW), .PER_W(PW)) u_dut8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_i(per_i), .duty_i(duty_i),
    .lvl_o(lvl8), .strb_o(strb8));

  function automatic int exp_lvl(int d, int c, int t, int h);
    longint lhs = longint'(d) * c * h;
    int n = 0;
    for (int k = 0; k < c; k++)
      if (lhs > (longint'(k) * h + t) * (longint'(1) << DW)) n++;
    return n;
  endfunction

  task automatic chk(bit ok, string t, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt <= 0; mup <= 1'b0; mhalf <= 2; mstrb <= 1'b0;
      for (int p = 0; p < 3; p++) mduty[p] <= 0;
    end else begin
      bit pk, vl;
      pk = mup && (mcnt == mhalf);
      vl = !mup && (mcnt == 0);
      mstrb <= pk || vl;
      if (pk || vl) for (int p = 0; p < 3; p++) mduty[p] <= int'(duty_i[p]);
      if (mup) begin
        if (pk) begin mup <= 1'b0; mcnt <= mcnt - 1; end
        else mcnt <= mcnt + 1;
      end else begin
        if (vl) begin
          mup <= 1'b1; mcnt <= 1;
          mhalf <= (int'(per_i) < 2) ? 2 : int'(per_i);
        end else mcnt <= mcnt - 1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (run_chk && rst_ni) begin
      for (int p = 0; p < 3; p++) begin
        int e5, e8;
        e5 = exp_lvl(mduty[p], 4, mcnt, mhalf);
        e8 = exp_lvl(mduty[p], 7, mcnt, mhalf);
        chk(int'(lvl5[p]) == e5, tag, $sformatf("lvl n5 ph%0d", p), int'(lvl5[p]), e5);
        chk(int'(lvl8[p]) == e8, tag, $sformatf("lvl n8 ph%0d", p), int'(lvl8[p]), e8);
      end
      chk(strb5 == mstrb, "R7", "strobe n5", int'(strb5), int'(mstrb));
      chk(strb8 == mstrb, "R7", "strobe n8", int'(strb8), int'(mstrb));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_all(int d);
    for (int p = 0; p < 3; p++) duty_i[p] = DW'(d);
  endtask

  task automatic wait_strb();
    @(negedge clk_i);
    while (!strb5) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        // R8: reset state
        cyc(3);
        for (int p = 0; p < 3; p++) begin
          chk(lvl5[p] == 0, "R8", "reset lvl n5", int'(lvl5[p]), 0);
          chk(lvl8[p] == 0, "R8", "reset lvl n8", int'(lvl8[p]), 0);
        end
        chk(strb5 == 1'b0, "R8", "reset strobe", int'(strb5), 0);
        duty_i = '{12'd4095, 12'd2000, 12'd100};
        rst_ni = 1'b1;
        run_chk = 1'b1;
        @(negedge clk_i);
        chk(strb5 == 1'b1, "R8", "first capture strobe", int'(strb5), 1);
        chk(int'(lvl5[2]) == exp_lvl(4095, 4, 1, 2), "R8", "first capture lvl",
            int'(lvl5[2]), exp_lvl(4095, 4, 1, 2));

        // R4: zero duty stays at level 0
        tag = "R4"; set_all(0); per_i = 4; cyc(20);
        for (int p = 0; p < 3; p++)
          chk(lvl8[p] == 0, "R4", "zero duty", int'(lvl8[p]), 0);

        // R4: full-scale duty reaches top level after a valley
        set_all(4095); cyc(12);
        @(negedge clk_i);
        while (!(strb5 && mup && mcnt == 1)) @(negedge clk_i);
        chk(int'(lvl5[0]) == 4, "R4", "top level n5", int'(lvl5[0]), 4);
        chk(int'(lvl8[1]) == 7, "R4", "top level n8", int'(lvl8[1]), 7);

        // R2: equal duties give equal levels
        tag = "R2"; set_all(1777); cyc(10);
        chk(lvl5[0] == lvl5[1] && lvl5[1] == lvl5[2], "R2", "equal duty n5",
            int'(lvl5[2]), int'(lvl5[0]));
        chk(lvl8[0] == lvl8[1] && lvl8[1] == lvl8[2], "R2", "equal duty n8",
            int'(lvl8[2]), int'(lvl8[0]));

        // R3: duties on band edges (equality is not above)
        tag = "R3"; per_i = 8;
        duty_i = '{12'd3072, 12'd2048, 12'd1024}; cyc(60);
        duty_i = '{12'd3073, 12'd2049, 12'd1025}; cyc(60);

        // R5: half-period change, and clamp of a too-small value
        tag = "R5"; per_i = 7; set_all(1500);
        wait_strb(); wait_strb(); wait_strb(); wait_strb();
        begin
          int gap = 0;
          @(negedge clk_i); gap = 1;
          while (!strb5) begin @(negedge clk_i); gap++; end
          chk(gap == 7, "R5", "strobe spacing", gap, 7);
        end
        per_i = 0;
        wait_strb(); wait_strb(); wait_strb(); wait_strb();
        begin
          int gap = 0;
          @(negedge clk_i); gap = 1;
          while (!strb5) begin @(negedge clk_i); gap++; end
          chk(gap == 2, "R5", "clamped spacing", gap, 2);
        end

        // R6: duty toggles every clock mid-ramp, only turning points count
        tag = "R6"; per_i = 30; set_all(500);
        wait_strb(); wait_strb(); wait_strb();
        begin
          int held = int'(lvl5[0]);
          int e = exp_lvl(500, 4, mcnt, mhalf);
          chk(held == e, "R6", "level before toggling", held, e);
        end
        for (int i = 0; i < 400; i++) begin
          for (int p = 0; p < 3; p++) duty_i[p] = DW'($urandom);
          @(negedge clk_i);
        end

        // R1: random half-periods and duties with corners
        tag = "R1";
        for (int i = 0; i < 6000; i++) begin
          if (i % 300 == 0) per_i = PW'(2 + $urandom_range(0, 38));
          if ($urandom_range(0, 3) == 0)
            for (int p = 0; p < 3; p++) begin
              int sel = $urandom_range(0, 5);
              duty_i[p] = (sel == 0) ? 12'd0 : (sel == 1) ? 12'd4095 : DW'($urandom);
            end
          @(negedge clk_i);
        end
        run_chk = 1'b0;
      end
      begin
        cyc(200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end
endmodule